// File: doc/BRIEF.md
# PCM Audio Channel FIFO with Compact Packing

This block is one audio channel that sits between a bus-side data register and the PCM slots of an AC'97 frame. Bus writes of 32-bit words go into a transmit FIFO. A slot strobe from the frame logic marks each PCM slot as it passes. When the slot is enabled in the transmit slot mask, the channel hands one 16-bit sample to that slot. The receive side works the other way. Samples arriving in enabled slots are gathered into a receive FIFO, and the bus reads them back from there.

Each direction has its own enable, FIFO-enable, compact-mode and slot-mask controls. In compact mode one 32-bit FIFO entry carries two 16-bit samples, so the entry count needed for a given number of samples is halved. Status outputs give empty, half-empty, full and busy for transmit, and empty, half-full, full and busy for receive. Clearing an enable leaves the FIFO contents in place. Only the re-initialise input empties the FIFOs. A channel that is enabled with an all-zero slot mask takes bus writes until it is full and never drains.

Top module: `pcm_chan_fifo`

## Requirements
- R1: After reset, and one cycle after `reinit` is pulsed, both FIFOs are empty: `tx_empty`=1, `tx_half_empty`=1, `rx_empty`=1, and `tx_full`, `tx_busy`, `rx_half_full`, `rx_full`, `rx_busy` are 0.
- R2: A `wr_en` cycle pushes `wr_data` into the transmit FIFO when it is not full. A write while it is full is dropped, and the stored entries keep their first-in, first-out order.
- R3: Without compact mode, a `slot_stb` on an enabled slot with `tx_en`=1 and a non-empty FIFO raises `tx_take` in the same cycle, drives `tx_sample` with bits 15:0 of the head entry, and pops that entry. On an empty FIFO or an unselected slot, `tx_take`=0 and `tx_sample`=0.
- R4: In compact mode, bits 15:0 of the head entry go to the first taking slot strobe and bits 31:16 go to the next one. The entry is popped after the second, so the lower half-word goes to the lower-numbered slot of each pair.
- R5: Mask bit i selects slot 3+i for i=0..6. Two channels use mask 7'b0000011, four channels use 7'b0110011, and six channels use 7'b1111011. Strobes on slot numbers below 3, above 9, or with a clear mask bit are ignored. With `tx_en`=1 and a zero mask, the FIFO never drains.
- R6: With `tx_en`=0, slot strobes take nothing, `tx_busy`=0, and the stored entries stay in the FIFO for when the channel is enabled again.
- R7: With `tx_fifo_on`=1 the capacity is DEPTH entries. `tx_half_empty` is 1 while the count is at most DEPTH/2, `tx_full` is 1 at DEPTH entries, and `tx_busy` = `tx_en` and not empty.
- R8: With the FIFO-enable bit of a direction at 0, that direction holds a single entry: full after one entry, and further writes are dropped.
- R9: Without compact mode, each received sample in an enabled slot is stored as {16'h0, sample}. In compact mode, the first sample fills bits 15:0 and the second fills bits 31:16 of one entry. `rd_data` shows the head entry, `rd_en` pops it, an empty FIFO reads as 0, and samples arriving while the FIFO is full are dropped.
- R10: `rx_half_full` is 1 at a count of at least DEPTH/2, and `rx_full` is 1 at DEPTH. `rx_busy` is 1 while `rx_en`=1 and a half-assembled compact word or stored data is present.
- R11: With `rx_en`=0, slot strobes store nothing into the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reinit | input | 1 | Empties both FIFOs and clears the half-word state |
| tx_en | input | 1 | Transmit channel enable |
| tx_fifo_on | input | 1 | Transmit FIFO enable (0 = single entry) |
| tx_compact | input | 1 | Transmit compact mode, two samples per entry |
| tx_slots | input | NSLOT | Transmit slot mask, bit i = slot 3+i |
| rx_en | input | 1 | Receive channel enable |
| rx_fifo_on | input | 1 | Receive FIFO enable (0 = single entry) |
| rx_compact | input | 1 | Receive compact mode |
| rx_slots | input | NSLOT | Receive slot mask, bit i = slot 3+i |
| wr_en | input | 1 | Bus write to the transmit data register |
| wr_data | input | DW | Bus write data |
| rd_en | input | 1 | Bus read pop of the receive data register |
| rd_data | output | DW | Receive head entry, 0 when empty |
| slot_stb | input | 1 | A frame slot is passing this cycle |
| slot_idx | input | 4 | Number of the slot passing |
| tx_sample | output | SW | Sample handed to the passing slot |
| tx_take | output | 1 | A sample was taken this cycle |
| rx_sample | input | SW | Sample received in the passing slot |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_half_empty | output | 1 | Transmit FIFO at most half full |
| tx_full | output | 1 | Transmit FIFO full |
| tx_busy | output | 1 | Transmit enabled with data pending |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_half_full | output | 1 | Receive FIFO at least half full |
| rx_full | output | 1 | Receive FIFO full |
| rx_busy | output | 1 | Receive enabled with data or half word pending |

## Verification
`tx_take` and `tx_sample` are combinational on the strobe. The bench reads them shortly after driving the strobe, in the same cycle. Writes, pops, received samples and `reinit` act at the next rising edge. The status flags and `rd_data` follow from the stored count, so they are due one edge after the stimulus. The bench therefore drives inputs on the falling edge and checks stored state on the following falling edge, exactly one register stage later.

// File: rtl/pcm_chan_fifo.sv
module pcm_chan_fifo #(
  parameter int DEPTH      = 16,
  parameter int DW         = 32,
  parameter int SW         = 16,
  parameter int NSLOT      = 7,
  parameter int FIRST_SLOT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reinit,
  input  logic             tx_en,
  input  logic             tx_fifo_on,
  input  logic             tx_compact,
  input  logic [NSLOT-1:0] tx_slots,
  input  logic             rx_en,
  input  logic             rx_fifo_on,
  input  logic             rx_compact,
  input  logic [NSLOT-1:0] rx_slots,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  input  logic             slot_stb,
  input  logic [3:0]       slot_idx,
  output logic [SW-1:0]    tx_sample,
  output logic             tx_take,
  input  logic [SW-1:0]    rx_sample,
  output logic             tx_empty,
  output logic             tx_half_empty,
  output logic             tx_full,
  output logic             tx_busy,
  output logic             rx_empty,
  output logic             rx_half_full,
  output logic             rx_full,
  output logic             rx_busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 2;

  logic [DW-1:0] tmem [DEPTH];
  logic [DW-1:0] rmem [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;
  logic          thalf, rhalf;
  logic [SW-1:0] rlow;
  logic          tsel, rsel;

  always_comb begin
    tsel = 1'b0;
    rsel = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_idx == 4'(FIRST_SLOT + i)) begin
        tsel = tx_slots[i];
        rsel = rx_slots[i];
      end
    end
  end

  wire [CW-1:0] tcap = tx_fifo_on ? CW'(DEPTH) : CW'(1);
  wire [CW-1:0] rcap = rx_fifo_on ? CW'(DEPTH) : CW'(1);

  assign tx_empty      = (tcnt == '0);
  assign tx_full       = (tcnt >= tcap);
  assign tx_half_empty = ({tcnt[CW-2:0], 1'b0} <= tcap);
  assign tx_busy       = tx_en && !tx_empty;
  assign rx_empty      = (rcnt == '0);
  assign rx_full       = (rcnt >= rcap);
  assign rx_half_full  = ({rcnt[CW-2:0], 1'b0} >= rcap);
  assign rx_busy       = rx_en && (rhalf || !rx_empty);

  wire [DW-1:0] thead = tmem[trp];
  assign tx_take   = slot_stb && tx_en && tsel && !tx_empty;
  assign tx_sample = !tx_take ? '0 :
                     (tx_compact && thalf) ? thead[2*SW-1:SW] : thead[SW-1:0];

  wire tpush = wr_en && !tx_full;
  wire tpop  = tx_take && (!tx_compact || thalf);

  wire rhit  = slot_stb && rx_en && rsel;
  wire rpush = rhit && (!rx_compact || rhalf) && !rx_full;
  wire rpop  = rd_en && !rx_empty;
  wire [DW-1:0] rword = rx_compact ? {rx_sample, rlow} : DW'(rx_sample);

  assign rd_data = rx_empty ? '0 : rmem[rrp];

  always_ff @(posedge clk) begin
    if (tpush) tmem[twp] <= wr_data;
    if (rpush) rmem[rwp] <= rword;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0; thalf <= 1'b0;
      rwp <= '0; rrp <= '0; rcnt <= '0; rhalf <= 1'b0; rlow <= '0;
    end else if (reinit) begin
      twp <= '0; trp <= '0; tcnt <= '0; thalf <= 1'b0;
      rwp <= '0; rrp <= '0; rcnt <= '0; rhalf <= 1'b0; rlow <= '0;
    end else begin
      if (tpush) twp <= twp + 1'b1;
      if (tpop)  trp <= trp + 1'b1;
      tcnt <= tcnt + CW'(tpush) - CW'(tpop);
      if (!tx_compact)  thalf <= 1'b0;
      else if (tx_take) thalf <= !thalf;

      if (rpush) rwp <= rwp + 1'b1;
      if (rpop)  rrp <= rrp + 1'b1;
      rcnt <= rcnt + CW'(rpush) - CW'(rpop);
      if (!rx_compact) rhalf <= 1'b0;
      else if (rhit) begin
        rhalf <= !rhalf;
        if (!rhalf) rlow <= rx_sample;
      end
    end
  end
endmodule

// File: rtl/pcm_chan_fifo_chk.sv
module pcm_chan_fifo_chk #(
  parameter int DW = 32,
  parameter int NSLOT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reinit,
  input logic             wr_en,
  input logic             tx_en,
  input logic [NSLOT-1:0] tx_slots,
  input logic             tx_take,
  input logic             tx_empty,
  input logic             tx_full,
  input logic             rx_empty,
  input logic [DW-1:0]    rd_data
);
  // R1
  reinit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (tx_empty && rx_empty));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && wr_en && !reinit) |=> !tx_empty);

  // R2
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_take && !reinit) |=> tx_full);

  // R5
  no_slot_no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slots == '0 && !tx_empty && !reinit) |=> !tx_empty);

  // R6
  disabled_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_take);

  // R9
  empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (rd_data == '0));
endmodule

bind pcm_chan_fifo pcm_chan_fifo_chk #(.DW(DW), .NSLOT(NSLOT)) chk_i (
  .clk(clk), .rst_n(rst_n), .reinit(reinit), .wr_en(wr_en), .tx_en(tx_en),
  .tx_slots(tx_slots), .tx_take(tx_take), .tx_empty(tx_empty),
  .tx_full(tx_full), .rx_empty(rx_empty), .rd_data(rd_data)
);

// File: tb/pcm_chan_fifo_test.sv
`timescale 1ns/100ps
module pcm_chan_fifo_test;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0, reinit = 0;
  logic tx_en = 0, tx_fifo_on = 1, tx_compact = 0;
  logic [6:0] tx_slots = '0;
  logic rx_en = 0, rx_fifo_on = 1, rx_compact = 0;
  logic [6:0] rx_slots = '0;
  logic wr_en = 0, rd_en = 0, slot_stb = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic [3:0] slot_idx = '0;
  logic [15:0] tx_sample, rx_sample = '0;
  logic tx_take, tx_empty, tx_half_empty, tx_full, tx_busy;
  logic rx_empty, rx_half_full, rx_full, rx_busy;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcm_chan_fifo #(.DEPTH(DEPTH)) uut (.*);

  // {slot, mask, expected take}
  localparam logic [11:0] VEC [9] = '{
    {4'd3,  7'b0000011, 1'b1}, {4'd4,  7'b0000011, 1'b1},
    {4'd7,  7'b0000011, 1'b0}, {4'd7,  7'b0110011, 1'b1},
    {4'd8,  7'b0110011, 1'b1}, {4'd6,  7'b0110011, 1'b0},
    {4'd9,  7'b1111011, 1'b1}, {4'd2,  7'b1111111, 1'b0},
    {4'd10, 7'b1111111, 1'b0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reinit();
    reinit = 1; cyc(); reinit = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0;
  endtask

  task automatic strobe(input logic [3:0] s, input logic [15:0] rs,
                        output logic tk, output logic [15:0] smp);
    slot_stb = 1; slot_idx = s; rx_sample = rs;
    #1 tk = tx_take; smp = tx_sample;
    cyc(); slot_stb = 0;
  endtask

  task automatic rd();
    rd_en = 1; cyc(); rd_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic tk;
    logic [15:0] smp;
    cyc(); cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 reset status", {24'h0, tx_empty, tx_half_empty, tx_full, tx_busy,
        rx_empty, rx_half_full, rx_full, rx_busy}, 32'h0000_00C8);

    // R5 / R3 slot mask table
    tx_en = 1;
    foreach (VEC[i]) begin
      do_reinit();
      tx_slots = VEC[i][7:1];
      wr({16'hC0DE, 12'h0, 4'(i)});
      strobe(VEC[i][11:8], 16'h0, tk, smp);
      chk("R5 mask take", 32'(tk), 32'(VEC[i][0]));
      chk("R3 sample", 32'(smp), VEC[i][0] ? {16'h0, 12'h0, 4'(i)} : 32'h0);
    end

    // R3 empty FIFO takes nothing
    do_reinit();
    tx_slots = 7'b0000011;
    strobe(4'd3, 16'h0, tk, smp);
    chk("R3 empty no take", {15'h0, tk, smp}, 32'h0);

    // R4 compact ordering
    tx_compact = 1;
    wr(32'h2222_1111); wr(32'h4444_3333);
    strobe(4'd3, 16'h0, tk, smp); chk("R4 compact slot3 low", 32'(smp), 32'h1111);
    chk("R4 entry kept after low half", 32'(tx_empty), 32'h0);
    strobe(4'd4, 16'h0, tk, smp); chk("R4 compact slot4 high", 32'(smp), 32'h2222);
    strobe(4'd3, 16'h0, tk, smp); chk("R4 second low", 32'(smp), 32'h3333);
    strobe(4'd4, 16'h0, tk, smp); chk("R4 second high", 32'(smp), 32'h4444);
    chk("R4 drained", 32'(tx_empty), 32'h1);
    tx_compact = 0;

    // R5 zero mask fills, never drains; R2 overflow dropped; R7 thresholds
    do_reinit();
    tx_slots = '0;
    for (int i = 0; i < DEPTH / 2; i++) wr(32'h100 + 32'(i));
    chk("R7 half-empty at DEPTH/2", 32'(tx_half_empty), 32'h1);
    wr(32'h100 + 32'(DEPTH / 2));
    chk("R7 half-empty clears", 32'(tx_half_empty), 32'h0);
    chk("R7 busy", 32'(tx_busy), 32'h1);
    for (int i = DEPTH / 2 + 1; i < DEPTH + 3; i++) wr(32'h100 + 32'(i));
    chk("R2 full", 32'(tx_full), 32'h1);
    strobe(4'd3, 16'h0, tk, smp);
    chk("R5 zero mask no take", 32'(tk), 32'h0);
    chk("R5 zero mask stays full", 32'(tx_full), 32'h1);

    // R6 disabled keeps data
    tx_en = 0; tx_slots = 7'b0000001;
    strobe(4'd3, 16'h0, tk, smp);
    chk("R6 disabled no take", 32'(tk), 32'h0);
    chk("R6 busy low", 32'(tx_busy), 32'h0);
    chk("R6 data retained", 32'(tx_full), 32'h1);
    tx_en = 1;
    for (int i = 0; i < DEPTH; i++) begin
      strobe(4'd3, 16'h0, tk, smp);
      chk("R2 order, overflow dropped", 32'(smp), 32'(16'h100 + 16'(i)));
    end
    chk("R2 empty after DEPTH pops", 32'(tx_empty), 32'h1);

    // R8 FIFO disabled holds one entry
    tx_fifo_on = 0; tx_slots = '0;
    wr(32'hAAAA_0001);
    chk("R8 single entry full", 32'(tx_full), 32'h1);
    wr(32'hAAAA_0002);
    tx_slots = 7'b0000001;
    strobe(4'd3, 16'h0, tk, smp);
    chk("R8 first kept", 32'(smp), 32'h0001);
    chk("R8 second dropped", 32'(tx_empty), 32'h1);
    tx_fifo_on = 1;

    // R1 reinit flushes
    tx_slots = '0;
    wr(32'h5); wr(32'h6);
    do_reinit();
    chk("R1 reinit flush", 32'(tx_empty), 32'h1);

    // R11 receive disabled
    rx_slots = 7'b0000011;
    strobe(4'd3, 16'h7777, tk, smp);
    chk("R11 rx disabled", 32'(rx_empty), 32'h1);

    // R9 non-compact receive
    rx_en = 1;
    strobe(4'd3, 16'hABCD, tk, smp);
    chk("R9 rx word", rd_data, 32'h0000_ABCD);
    strobe(4'd5, 16'h9999, tk, smp);
    chk("R9 unselected slot ignored", rd_data, 32'h0000_ABCD);
    rd();
    chk("R9 empty read zero", rd_data, 32'h0);

    // R9 / R10 compact receive
    rx_compact = 1;
    strobe(4'd3, 16'h1111, tk, smp);
    chk("R10 busy with half word", {30'h0, rx_busy, rx_empty}, 32'h3);
    strobe(4'd4, 16'h2222, tk, smp);
    chk("R9 compact pair", rd_data, 32'h2222_1111);
    rd();
    rx_compact = 0;

    // R10 thresholds and overflow
    for (int i = 0; i < DEPTH / 2 - 1; i++) strobe(4'd3, 16'(i + 1), tk, smp);
    chk("R10 below half", 32'(rx_half_full), 32'h0);
    strobe(4'd3, 16'(DEPTH / 2), tk, smp);
    chk("R10 half-full", 32'(rx_half_full), 32'h1);
    for (int i = DEPTH / 2; i < DEPTH + 2; i++) strobe(4'd3, 16'(i + 1), tk, smp);
    chk("R10 full", 32'(rx_full), 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R9 rx order, overflow dropped", rd_data, 32'(i + 1));
      rd();
    end
    chk("R9 rx empty", {31'h0, rx_empty}, 32'h1);

    finish_run();
  end
endmodule